// File: doc/BRIEF.md
# Microprogrammed Pulse Pattern Sequencer

This block is a compact timing processor that plays back a stored program of 80-bit instruction words. Each word sets a pattern on 21 flag outputs and holds it for its own delay count. A 3-bit control field can cut the pattern down to a short pulse at the start of the instruction. When the hold time runs out, an opcode picks the next word: sequential advance, halt, nested counted loops, an unconditional jump, or a pause until an external trigger arrives.

A host fills the program memory through a simple write port while the sequencer is not executing. Execution starts from address 0 on a software start strobe or on a falling edge of the active-low hardware trigger. An active-low hardware reset, or a software reset strobe, returns the block to address 0 with all flags low. Four one-hot status lines report the controller state.

The controller has four named states:
- RESET is entered on power-up, while the hardware reset is held, and after a software reset strobe. It always moves to IDLE one cycle later.
- IDLE is the stopped state. A start (trigger fall or software start) moves it to RUN.
- RUN executes an instruction. When the count expires it stays in RUN on the next word, goes to IDLE on STOP, or goes to HOLD on WAIT.
- HOLD waits for a trigger. A start moves it back to RUN at the following address.

A software reset strobe moves any state to RESET.

Top module: `pulse_seq_top`

## Requirements
- R1: The word layout, from MSB to LSB, is control[79:56], opcode[55:52], argument[51:32] and delay[31:0]. Control bits [20:0] are the flag pattern. An instruction lasts max(delay,2)+3 clock cycles, and CONTINUE (opcode 0) then advances to the next address.
- R2: Control bits [23:21] form a pulse code. Code 0 keeps the flags low for the whole instruction. Codes 1 to 5 drive the pattern for that many cycles from the start of the instruction and then keep the flags low. Codes 6 and 7 drive the pattern for the whole instruction.
- R3: LOOP (opcode 2) with count N (N=0 is taken as 1) and END_LOOP (opcode 3), whose argument is the LOOP address, repeat the enclosed body N times. Loops may nest up to 8 levels deep.
- R4: BRANCH (opcode 4) continues at the address held in the low argument bits.
- R5: STOP (opcode 1) enters IDLE when its hold time ends. While in IDLE or RESET, all flags are low.
- R6: WAIT (opcode 5) enters HOLD after its hold time ends. HOLD keeps the pulse gating of the WAIT instruction. A start in HOLD resumes at the following address.
- R7: In IDLE, a sw_start strobe or a falling edge on hw_trig_n (after a two-flop synchronizer) begins execution at address 0. The first instruction appears on the flags in the cycle after the strobe is sampled.
- R8: hw_rst_n low forces RESET at once, with flags low. A sw_reset strobe enters RESET at the next clock edge. RESET moves to IDLE one cycle after it is released.
- R9: status_o is one-hot: bit0 IDLE, bit1 RESET, bit2 RUN, bit3 HOLD.
- R10: Program writes take effect only in IDLE or RESET. A write in RUN or HOLD leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| hw_trig_n | input | 1 | Hardware trigger, active low, falling edge acts |
| sw_start | input | 1 | Software start strobe |
| sw_reset | input | 1 | Software reset strobe |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | ADDR_W | Program memory write address |
| prog_data | input | 80 | Program word to write |
| flags_o | output | 21 | Gated flag pattern |
| status_o | output | 4 | One-hot state: IDLE, RESET, RUN, HOLD |

## Verification
The bench builds the block with the default parameters: a 64-word program, an 8-level loop stack and two synchronizer stages. The programs use delay counts of 0 to 4. This keeps every instruction between 5 and 7 cycles long, so that the delay clamp, each class of pulse code and a two-level nested loop can all be checked cycle by cycle within a few hundred cycles. The default synchronizer depth fixes the trigger latency, so the bench measures resume points from the status change.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

    localparam int WORD_W  = 80;
    localparam int CTRL_W  = 24;
    localparam int FLAG_W  = 21;
    localparam int CODE_W  = 3;
    localparam int OP_W    = 4;
    localparam int ARG_W   = 20;
    localparam int DLY_W   = 32;
    localparam int CNT_W   = DLY_W + 1;
    localparam int AGE_W   = 3;

    localparam logic [DLY_W-1:0]  DLY_MIN   = 32'd2;
    localparam logic [CNT_W-1:0]  OVERHEAD  = 33'd2;
    localparam logic [CODE_W-1:0] PULSE_MAX = 3'd5;
    localparam logic [AGE_W-1:0]  AGE_SAT   = 3'd7;

    localparam logic [OP_W-1:0] OP_CONT   = 4'd0;
    localparam logic [OP_W-1:0] OP_STOP   = 4'd1;
    localparam logic [OP_W-1:0] OP_LOOP   = 4'd2;
    localparam logic [OP_W-1:0] OP_ENDL   = 4'd3;
    localparam logic [OP_W-1:0] OP_BRANCH = 4'd4;
    localparam logic [OP_W-1:0] OP_WAIT   = 4'd5;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [OP_W-1:0]   op;
        logic [ARG_W-1:0]  arg;
        logic [DLY_W-1:0]  dly;
    } word_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [OP_W-1:0]   op;
        logic [ARG_W-1:0]  arg;
    } exec_t;

    typedef enum logic [1:0] {
        S_RESET = 2'd0,
        S_IDLE  = 2'd1,
        S_RUN   = 2'd2,
        S_HOLD  = 2'd3
    } state_e;

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic hw_trig_n,
    output logic rst_n_o,
    output logic trig_fall_o
);

    logic [STAGES-1:0] rst_q;
    logic [STAGES:0]   trig_q;

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            rst_q <= '0;
        end else begin
            rst_q <= {rst_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_o = rst_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n_o) begin
        if (!rst_n_o) begin
            trig_q <= '1;
        end else begin
            trig_q <= {trig_q[STAGES-1:0], hw_trig_n};
        end
    end

    assign trig_fall_o = trig_q[STAGES] & ~trig_q[STAGES-1];

endmodule

// File: rtl/ps_progmem.sv
module ps_progmem #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 80
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ps_loopstack.sv
module ps_loopstack #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [CNT_W-1:0]  push_cnt,
    input  logic              dec,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [ADDR_W-1:0] top_addr,
    output logic [CNT_W-1:0]  top_cnt
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);
    localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);

    logic [SP_W-1:0]   sp_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q  [DEPTH];
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  new_idx;

    assign empty    = (sp_q == '0);
    assign full     = (sp_q == SP_FULL);
    assign top_idx  = IDX_W'(sp_q - SP_ONE);
    assign new_idx  = IDX_W'(sp_q);
    assign top_addr = addr_q[top_idx];
    assign top_cnt  = cnt_q[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                cnt_q[i]  <= '0;
            end
        end else if (clear) begin
            sp_q <= '0;
        end else if (push && !full) begin
            addr_q[new_idx] <= push_addr;
            cnt_q[new_idx]  <= push_cnt;
            sp_q            <= sp_q + SP_ONE;
        end else if (pop && !empty) begin
            sp_q <= sp_q - SP_ONE;
        end else if (dec && !empty) begin
            cnt_q[top_idx] <= cnt_q[top_idx] - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ps_flaggate.sv
module ps_flaggate
    import pulse_seq_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [AGE_W-1:0]  age,
    input  logic              active,
    output logic [FLAG_W-1:0] flags
);

    logic [CODE_W-1:0] code;

    assign code = ctrl[CTRL_W-1 -: CODE_W];

    always_comb begin
        flags = '0;
        if (active) begin
            if (code == '0) begin
                flags = '0;
            end else if (code <= PULSE_MAX) begin
                flags = (age < code) ? ctrl[FLAG_W-1:0] : '0;
            end else begin
                flags = ctrl[FLAG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top
    import pulse_seq_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int STACK_DEPTH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              hw_trig_n,
    input  logic              sw_start,
    input  logic              sw_reset,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [79:0]       prog_data,
    output logic [20:0]       flags_o,
    output logic [3:0]        status_o
);

    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

    logic              rst_n;
    logic              trig_fall;
    logic              go;
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    exec_t             cur_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [AGE_W-1:0]  age_q;
    logic              in_run, in_hold, in_stop, done;
    logic              load_en;
    logic [ADDR_W-1:0] load_addr, nxt_addr;
    logic [WORD_W-1:0] rdata;
    word_t             fetch;
    logic [DLY_W-1:0]  dly_eff;
    logic [CNT_W-1:0]  fetch_cnt;
    logic              stk_empty, stk_full, stk_push, stk_pop, stk_dec;
    logic [ADDR_W-1:0] stk_addr;
    logic [ARG_W-1:0]  stk_cnt, push_cnt;
    logic              reenter, loop_more;

    ps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .hw_trig_n   (hw_trig_n),
        .rst_n_o     (rst_n),
        .trig_fall_o (trig_fall)
    );

    assign go      = trig_fall | sw_start;
    assign in_run  = (state_q == S_RUN);
    assign in_hold = (state_q == S_HOLD);
    assign in_stop = (state_q == S_IDLE) || (state_q == S_RESET);
    assign done    = in_run && (cnt_q == '0);

    ps_progmem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (prog_we && in_stop),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (load_addr),
        .rdata (rdata)
    );

    assign fetch     = word_t'(rdata);
    assign dly_eff   = (fetch.dly < DLY_MIN) ? DLY_MIN : fetch.dly;
    assign fetch_cnt = {1'b0, dly_eff} + OVERHEAD;

    // loop bookkeeping
    assign reenter   = !stk_empty && (stk_addr == pc_q);
    assign loop_more = !stk_empty && (stk_cnt != '0);
    assign push_cnt  = (cur_q.arg == '0) ? '0 : cur_q.arg - ARG_W'(1);
    assign stk_push  = done && !sw_reset && (cur_q.op == OP_LOOP) && !reenter;
    assign stk_pop   = done && !sw_reset && (cur_q.op == OP_ENDL) && !stk_empty && !loop_more;
    assign stk_dec   = done && !sw_reset && (cur_q.op == OP_ENDL) && loop_more;

    ps_loopstack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W), .CNT_W(ARG_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (in_stop),
        .push      (stk_push),
        .push_addr (pc_q),
        .push_cnt  (push_cnt),
        .dec       (stk_dec),
        .pop       (stk_pop),
        .empty     (stk_empty),
        .full      (stk_full),
        .top_addr  (stk_addr),
        .top_cnt   (stk_cnt)
    );

    always_comb begin
        nxt_addr = pc_q + A_ONE;
        unique case (cur_q.op)
            OP_BRANCH: nxt_addr = cur_q.arg[ADDR_W-1:0];
            OP_ENDL:   nxt_addr = loop_more ? cur_q.arg[ADDR_W-1:0] : pc_q + A_ONE;
            default:   nxt_addr = pc_q + A_ONE;
        endcase
    end

    // next state and load control
    always_comb begin
        state_d   = state_q;
        load_en   = 1'b0;
        load_addr = pc_q + A_ONE;
        unique case (state_q)
            S_RESET: begin
                state_d = sw_reset ? S_RESET : S_IDLE;
            end
            S_IDLE: begin
                load_addr = '0;
                if (sw_reset) begin
                    state_d = S_RESET;
                end else if (go) begin
                    state_d = S_RUN;
                    load_en = 1'b1;
                end
            end
            S_RUN: begin
                load_addr = nxt_addr;
                if (sw_reset) begin
                    state_d = S_RESET;
                end else if (done) begin
                    if (cur_q.op == OP_STOP) begin
                        state_d = S_IDLE;
                    end else if (cur_q.op == OP_WAIT) begin
                        state_d = S_HOLD;
                    end else begin
                        load_en = 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (sw_reset) begin
                    state_d = S_RESET;
                end else if (go) begin
                    state_d = S_RUN;
                    load_en = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // instruction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            cur_q <= '0;
            cnt_q <= '0;
            age_q <= '0;
        end else if (load_en) begin
            pc_q  <= load_addr;
            cur_q <= '{ctrl: fetch.ctrl, op: fetch.op, arg: fetch.arg};
            cnt_q <= fetch_cnt;
            age_q <= '0;
        end else begin
            if (in_run && (cnt_q != '0)) begin
                cnt_q <= cnt_q - C_ONE;
            end
            if ((in_run || in_hold) && (age_q != AGE_SAT)) begin
                age_q <= age_q + AGE_W'(1);
            end
            if (in_stop) begin
                pc_q <= '0;
            end
        end
    end

    ps_flaggate u_gate (
        .ctrl   (cur_q.ctrl),
        .age    (age_q),
        .active (in_run || in_hold),
        .flags  (flags_o)
    );

    // status outputs
    always_comb begin
        status_o = '0;
        unique case (state_q)
            S_IDLE:  status_o[0] = 1'b1;
            S_RESET: status_o[1] = 1'b1;
            S_RUN:   status_o[2] = 1'b1;
            S_HOLD:  status_o[3] = 1'b1;
        endcase
    end

endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk
    import pulse_seq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        status,
    input logic [20:0]       flags,
    input logic              in_run,
    input logic              in_hold,
    input logic              go,
    input logic              sw_reset,
    input logic              done,
    input logic [OP_W-1:0]   op,
    input logic [CTRL_W-1:0] ctrl,
    input logic [ARG_W-1:0]  arg,
    input logic [ADDR_W-1:0] pc,
    input logic [CNT_W-1:0]  cnt
);

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(status)); // R9

    AST_STOPPED_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] || status[1]) |-> (flags == '0)); // R5

    AST_CODE_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && ctrl[23:21] == 3'd0) |-> (flags == '0)); // R2

    AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sw_reset && op == OP_CONT) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R1

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sw_reset && op == OP_CONT) |=> (cnt >= CNT_W'(4))); // R1

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sw_reset && op == OP_BRANCH) |=> (pc == $past(arg[ADDR_W-1:0]))); // R4

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sw_reset && op == OP_STOP) |=> status[0]); // R5

    AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && go && !sw_reset) |=> (in_run && pc == ADDR_W'($past(pc) + 1'b1))); // R6

    AST_SWRESET_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> status[1]); // R8

endmodule

bind pulse_seq_top pulse_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status_o),
    .flags    (flags_o),
    .in_run   (in_run),
    .in_hold  (in_hold),
    .go       (go),
    .sw_reset (sw_reset),
    .done     (done),
    .op       (cur_q.op),
    .ctrl     (cur_q.ctrl),
    .arg      (cur_q.arg),
    .pc       (pc_q),
    .cnt      (cnt_q)
);

// File: tb/pulse_seq_top_tb.sv
module pulse_seq_top_tb;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          hw_rst_n = 1'b0;
    logic          hw_trig_n = 1'b1;
    logic          sw_start = 1'b0;
    logic          sw_reset = 1'b0;
    logic          prog_we = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [79:0]   prog_data = '0;
    logic [20:0]   flags_o;
    logic [3:0]    status_o;

    int total = 0;
    int bad   = 0;

    localparam logic [3:0] ST_IDLE = 4'b0001, ST_RST = 4'b0010,
                           ST_RUN  = 4'b0100, ST_HOLD = 4'b1000;

    pulse_seq_top #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .hw_rst_n  (hw_rst_n),
        .hw_trig_n (hw_trig_n),
        .sw_start  (sw_start),
        .sw_reset  (sw_reset),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .flags_o   (flags_o),
        .status_o  (status_o)
    );

    always #4 clk = ~clk;

    function automatic logic [79:0] mk(input logic [20:0] f, input logic [2:0] code,
                                       input logic [3:0] op, input logic [19:0] arg,
                                       input logic [31:0] dly);
        return {code, f, op, arg, dly};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [79:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a; prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic seg(input logic [20:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check(tag, 32'(flags_o), 32'(v));
            @(negedge clk);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic wait_run(input string tag);
        int n = 0;
        while (status_o != ST_RUN && n < 20) begin
            @(negedge clk); n++;
        end
        check(tag, 32'(status_o), 32'(ST_RUN));
    endtask

    // reset state and release
    task automatic t_reset_state();
        @(negedge clk);
        check("R8 reset status", 32'(status_o), 32'(ST_RST));
        check("R8 reset flags", 32'(flags_o), 32'd0);
        hw_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 idle status", 32'(status_o), 32'(ST_IDLE));
    endtask

    // timing, pulse codes, nested loops, stop
    task automatic t_loops();
        load(0, mk(21'h1,   3'd7, 4'd0, 20'd0, 32'd2));
        load(1, mk(21'h2,   3'd2, 4'd0, 20'd0, 32'd4));
        load(2, mk(21'h4,   3'd0, 4'd0, 20'd0, 32'd0));
        load(3, mk(21'h10,  3'd7, 4'd2, 20'd2, 32'd2));
        load(4, mk(21'h20,  3'd7, 4'd2, 20'd3, 32'd2));
        load(5, mk(21'h40,  3'd7, 4'd3, 20'd4, 32'd2));
        load(6, mk(21'h80,  3'd6, 4'd3, 20'd3, 32'd2));
        load(7, mk(21'h100, 3'd7, 4'd1, 20'd0, 32'd3));
        pulse_start();
        seg(21'h1, 5, "R1 R7 first word length");
        seg(21'h2, 2, "R2 short pulse");
        seg(21'h0, 10, "R2 code zero R1 clamp");
        for (int o = 0; o < 2; o++) begin
            seg(21'h10, 5, "R3 outer");
            for (int i = 0; i < 3; i++) begin
                seg(21'h20, 5, "R3 inner loop");
                seg(21'h40, 5, "R3 inner end");
            end
            seg(21'h80, 5, "R2 reserved code");
        end
        seg(21'h100, 6, "R5 stop word");
        check("R5 stopped status", 32'(status_o), 32'(ST_IDLE));
        check("R5 stopped flags", 32'(flags_o), 32'd0);
    endtask

    // wait, trigger resume, branch, ignored write
    task automatic t_wait_branch();
        load(0, mk(21'h3,    3'd7, 4'd5, 20'd0, 32'd2));
        load(1, mk(21'h5,    3'd7, 4'd4, 20'd3, 32'd2));
        load(2, mk(21'hAAA,  3'd7, 4'd1, 20'd0, 32'd2));
        load(3, mk(21'h7,    3'd7, 4'd1, 20'd0, 32'd2));
        @(negedge clk); hw_trig_n = 1'b0;
        wait_run("R7 trigger start");
        seg(21'h3, 5, "R6 wait word");
        check("R6 hold status", 32'(status_o), 32'(ST_HOLD));
        hw_trig_n = 1'b1;
        load(1, mk(21'h1FFFFF, 3'd7, 4'd0, 20'd0, 32'd2));
        repeat (3) @(negedge clk);
        check("R6 hold flags", 32'(flags_o), 32'h3);
        check("R6 still holding", 32'(status_o), 32'(ST_HOLD));
        hw_trig_n = 1'b0;
        wait_run("R6 resume");
        seg(21'h5, 5, "R10 write ignored");
        seg(21'h7, 5, "R4 branch target");
        check("R5 stop after branch", 32'(status_o), 32'(ST_IDLE));
        hw_trig_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // hardware and software reset during execution
    task automatic t_resets();
        pulse_start();
        seg(21'h3, 2, "R7 restart");
        hw_rst_n = 1'b0;
        #1;
        check("R8 async reset status", 32'(status_o), 32'(ST_RST));
        check("R8 async reset flags", 32'(flags_o), 32'd0);
        @(negedge clk); hw_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 back to idle", 32'(status_o), 32'(ST_IDLE));
        pulse_start();
        seg(21'h3, 5, "R8 restart at zero");
        check("R6 hold again", 32'(status_o), 32'(ST_HOLD));
        sw_reset = 1'b1;
        @(negedge clk); sw_reset = 1'b0;
        check("R8 soft reset", 32'(status_o), 32'(ST_RST));
        check("R8 soft reset flags", 32'(flags_o), 32'd0);
        @(negedge clk);
        check("R8 soft reset release", 32'(status_o), 32'(ST_IDLE));
    endtask

    initial begin
        t_reset_state();
        t_loops();
        t_wait_branch();
        t_resets();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule